// File: doc/BRIEF.md
# UART Interrupt Priority and Identification Unit

This block collects every interrupt condition of one serial channel and turns them into a single active-high interrupt request and a 6-bit identification code. Each condition has its own pending latch. A pulse from the receiver, the transmitter, the modem-status logic, the flow-control character matcher or a handshake-pin edge sets that latch. The latch stays set until its own clearing action arrives, which is a particular register read or write, or a later matcher event. Among the pending sources that are enabled, the one with the highest rank is reported. The others stay latched and come into view once the higher ones have been serviced.

Software chooses between interrupt mode and polled mode with a 4-bit enable nibble. When the nibble is zero the request line never asserts and the code reads idle. When any bit is set, each bit admits its own group of sources. The flow-control and handshake-pin sources are admitted whenever interrupt mode is active. The bus decode, the FIFOs, the serial shifters and the character comparators sit outside and supply one-cycle strobes to this unit.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `irq` is 0 and `ident_code` is 000001 (nothing pending). These values hold while `rst` is high.
- R2: A line-status error event gives code 000110. This source has the highest rank and outranks all others. It is cleared only by `rd_line_stat`. A receive-holding read leaves it pending.
- R3: A receive timeout gives code 001100 and a receive data event gives code 000100. Both share the second rank, and the timeout is shown ahead of data. Both are cleared by `rd_rx_hold`.
- R4: A transmit-ready event gives code 000010 (third rank). It is cleared by `wr_tx_hold`, or by `rd_ident` in a cycle where 000010 is the code being reported.
- R5: An `rd_ident` clears only the source whose code is reported in that same cycle. Other pending sources stay latched and are shown afterwards.
- R6: A modem-status event gives code 000000 (fourth rank). It is cleared only by `rd_modem_stat`.
- R7: Flow-control sources give code 010000 (fifth rank). When an Xoff match set the source, only a later Xon match clears it, and `rd_ident` has no effect. When a special-character match set it, `rd_ident` while it is reported clears it.
- R8: A low-to-high transition on `rts_n_pin` or `cts_n_pin` gives code 100000 (sixth rank). A high-to-low transition does not. This source is cleared by `rd_ident` while it is reported.
- R9: Enable bit 0 admits receive timeout and receive data. Bit 1 admits transmit-ready, bit 2 admits line status and bit 3 admits modem status. Flow-control and handshake-pin sources are admitted when any bit is set. With the nibble at 0000, `irq` stays 0 and the code reads 000001. Otherwise `irq` is 1 exactly when the code differs from 000001.
- R10: When a set event and a clear action for the same source fall in the same cycle, the source ends up pending.
- R11: A set or clear strobe sampled at a rising clock edge changes `irq` and `ident_code` just after that edge and not before it.
- R12: Pending latches are kept while their source is disabled. A source set while disabled is reported as soon as its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ier_en | input | 4 | Interrupt enable nibble |
| ev_line_err | input | 1 | Receive line error event pulse |
| ev_rx_timeout | input | 1 | Receive timeout event pulse |
| ev_rx_data | input | 1 | Receive data ready or trigger event pulse |
| ev_tx_ready | input | 1 | Transmit holding empty or trigger event pulse |
| ev_modem | input | 1 | Modem status change event pulse |
| ev_xoff_match | input | 1 | Xoff character matched |
| ev_xon_match | input | 1 | Xon character matched |
| ev_special_match | input | 1 | Special character matched |
| rts_n_pin | input | 1 | Request-to-send pin level, active low |
| cts_n_pin | input | 1 | Clear-to-send pin level, active low |
| rd_ident | input | 1 | Identification register read strobe |
| rd_line_stat | input | 1 | Line status register read strobe |
| rd_rx_hold | input | 1 | Receive holding register read strobe |
| rd_modem_stat | input | 1 | Modem status register read strobe |
| wr_tx_hold | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request, active high |
| ident_code | output | 6 | Code of the highest-ranked enabled pending source |

## Verification
The properties assume that every event and access strobe lasts exactly one clock cycle. They also assume that the handshake pins sit at their inactive high level while reset is held, so that the first cycle after reset cannot show an edge that the detector never saw. The bench drives all inputs on the falling clock edge. It drops every strobe back to zero after one cycle and keeps both pins high through each reset. The clear-effect properties guard against a same-cycle re-set by excluding the matching set event, and they admit a disabled source through the enable term rather than assuming the enables stay fixed.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int CODE_W = 6;
    localparam int NSRC   = 7;
    localparam int SRC_IW = $clog2(NSRC);
    localparam int NLATCH = 8;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SRC_IW-1:0] src_idx_t;

    // Rank order: lower index wins
    localparam int S_LINE  = 0;
    localparam int S_RXTO  = 1;
    localparam int S_RXDAT = 2;
    localparam int S_TXRDY = 3;
    localparam int S_MODEM = 4;
    localparam int S_FLOW  = 5;
    localparam int S_PIN   = 6;

    // Latch slots: flow source is split by cause
    localparam int L_LINE  = 0;
    localparam int L_RXTO  = 1;
    localparam int L_RXDAT = 2;
    localparam int L_TXRDY = 3;
    localparam int L_MODEM = 4;
    localparam int L_XOFF  = 5;
    localparam int L_SPEC  = 6;
    localparam int L_PIN   = 7;

    localparam code_t CODE_IDLE  = 6'b000001;
    localparam code_t CODE_LINE  = 6'b000110;
    localparam code_t CODE_RXTO  = 6'b001100;
    localparam code_t CODE_RXDAT = 6'b000100;
    localparam code_t CODE_TXRDY = 6'b000010;
    localparam code_t CODE_MODEM = 6'b000000;
    localparam code_t CODE_FLOW  = 6'b010000;
    localparam code_t CODE_PIN   = 6'b100000;

    typedef struct packed {
        logic ident;
        logic line_stat;
        logic rx_hold;
        logic modem_stat;
        logic tx_wr;
    } access_t;

    typedef struct packed {
        logic line_err;
        logic rx_timeout;
        logic rx_data;
        logic tx_ready;
        logic modem;
        logic xoff;
        logic xon;
        logic special;
    } event_t;

    function automatic code_t code_of(input src_idx_t idx);
        code_t c;
        case (idx)
            3'd0:    c = CODE_LINE;
            3'd1:    c = CODE_RXTO;
            3'd2:    c = CODE_RXDAT;
            3'd3:    c = CODE_TXRDY;
            3'd4:    c = CODE_MODEM;
            3'd5:    c = CODE_FLOW;
            3'd6:    c = CODE_PIN;
            default: c = CODE_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[g] <= 1'b0;
            else if (set_i[g])
                pend_o[g] <= 1'b1;
            else if (clr_i[g])
                pend_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int N  = 7,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        grant_o = '0;
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pin_rise_det.sv
module pin_rise_det #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_i,
    output logic            rise_o
);
    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] rise_v;

    always_ff @(posedge clk) begin
        prev_q <= pin_i;
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign rise_v[g] = pin_i[g] & ~prev_q[g];
    end

    assign rise_o = (|rise_v) & ~rst;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] ier_en,
    input  logic       ev_line_err,
    input  logic       ev_rx_timeout,
    input  logic       ev_rx_data,
    input  logic       ev_tx_ready,
    input  logic       ev_modem,
    input  logic       ev_xoff_match,
    input  logic       ev_xon_match,
    input  logic       ev_special_match,
    input  logic       rts_n_pin,
    input  logic       cts_n_pin,
    input  logic       rd_ident,
    input  logic       rd_line_stat,
    input  logic       rd_rx_hold,
    input  logic       rd_modem_stat,
    input  logic       wr_tx_hold,
    output logic       irq,
    output logic [5:0] ident_code
);
    event_t  ev;
    access_t acc;

    assign ev  = '{line_err: ev_line_err, rx_timeout: ev_rx_timeout,
                   rx_data: ev_rx_data, tx_ready: ev_tx_ready,
                   modem: ev_modem, xoff: ev_xoff_match,
                   xon: ev_xon_match, special: ev_special_match};
    assign acc = '{ident: rd_ident, line_stat: rd_line_stat,
                   rx_hold: rd_rx_hold, modem_stat: rd_modem_stat,
                   tx_wr: wr_tx_hold};

    logic              pin_rise;
    logic [NLATCH-1:0] lset;
    logic [NLATCH-1:0] lclr;
    logic [NLATCH-1:0] lpend;
    logic [NSRC-1:0]   src_pend;
    logic [NSRC-1:0]   src_mask;
    logic [NSRC-1:0]   grant;
    logic              found;
    src_idx_t          win_idx;
    logic              int_mode;

    pin_rise_det #(.NPIN(2)) u_pins (
        .clk    (clk),
        .rst    (rst),
        .pin_i  ({cts_n_pin, rts_n_pin}),
        .rise_o (pin_rise)
    );

    always_comb begin
        lset          = '0;
        lset[L_LINE]  = ev.line_err;
        lset[L_RXTO]  = ev.rx_timeout;
        lset[L_RXDAT] = ev.rx_data;
        lset[L_TXRDY] = ev.tx_ready;
        lset[L_MODEM] = ev.modem;
        lset[L_XOFF]  = ev.xoff;
        lset[L_SPEC]  = ev.special;
        lset[L_PIN]   = pin_rise;
    end

    // Identification-read clears act on the source granted this cycle
    always_comb begin
        lclr          = '0;
        lclr[L_LINE]  = acc.line_stat;
        lclr[L_RXTO]  = acc.rx_hold;
        lclr[L_RXDAT] = acc.rx_hold;
        lclr[L_TXRDY] = acc.tx_wr | (acc.ident & grant[S_TXRDY]);
        lclr[L_MODEM] = acc.modem_stat;
        lclr[L_XOFF]  = ev.xon;
        lclr[L_SPEC]  = acc.ident & grant[S_FLOW];
        lclr[L_PIN]   = acc.ident & grant[S_PIN];
    end

    irq_pend_latch #(.N(NLATCH)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .set_i  (lset),
        .clr_i  (lclr),
        .pend_o (lpend)
    );

    assign int_mode = |ier_en;

    always_comb begin
        src_pend          = '0;
        src_pend[S_LINE]  = lpend[L_LINE];
        src_pend[S_RXTO]  = lpend[L_RXTO];
        src_pend[S_RXDAT] = lpend[L_RXDAT];
        src_pend[S_TXRDY] = lpend[L_TXRDY];
        src_pend[S_MODEM] = lpend[L_MODEM];
        src_pend[S_FLOW]  = lpend[L_XOFF] | lpend[L_SPEC];
        src_pend[S_PIN]   = lpend[L_PIN];

        src_mask          = '0;
        src_mask[S_LINE]  = ier_en[2];
        src_mask[S_RXTO]  = ier_en[0];
        src_mask[S_RXDAT] = ier_en[0];
        src_mask[S_TXRDY] = ier_en[1];
        src_mask[S_MODEM] = ier_en[3];
        src_mask[S_FLOW]  = int_mode;
        src_mask[S_PIN]   = int_mode;
    end

    irq_prio_sel #(.N(NSRC)) u_sel (
        .req_i   (src_pend & src_mask),
        .grant_o (grant),
        .found_o (found),
        .idx_o   (win_idx)
    );

    assign ident_code = found ? code_of(win_idx) : CODE_IDLE;
    assign irq        = found;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] ier_en,
    input logic       ev_line_err,
    input logic       ev_modem,
    input logic       ev_tx_ready,
    input logic       rts_n_pin,
    input logic       rd_modem_stat,
    input logic       wr_tx_hold,
    input logic       irq,
    input logic [5:0] ident_code
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!irq && ident_code == 6'b000001)); // R1

    AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ier_en == 4'b0000) |-> (!irq && ident_code == 6'b000001)); // R9

    AST_IRQ_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
        (ier_en != 4'b0000) |-> (irq == (ident_code != 6'b000001))); // R9

    AST_LINE_TOP: assert property (@(posedge clk) disable iff (rst)
        (ev_line_err && ier_en[2]) |=> (!ier_en[2] || ident_code == 6'b000110)); // R2

    AST_MODEM_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (rd_modem_stat && !ev_modem) |=> (ident_code != 6'b000000)); // R6

    AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_tx_hold && !ev_tx_ready) |=> (ident_code != 6'b000010)); // R4

    AST_PIN_RISE_PENDS: assert property (@(posedge clk) disable iff (rst)
        ($rose(rts_n_pin) && ier_en != 4'b0000) |=>
            (ier_en == 4'b0000 || ident_code != 6'b000001)); // R8
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ier_en        (ier_en),
    .ev_line_err   (ev_line_err),
    .ev_modem      (ev_modem),
    .ev_tx_ready   (ev_tx_ready),
    .rts_n_pin     (rts_n_pin),
    .rd_modem_stat (rd_modem_stat),
    .wr_tx_hold    (wr_tx_hold),
    .irq           (irq),
    .ident_code    (ident_code)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 28;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ier_en = 4'h0;
    logic       ev_line_err = 0, ev_rx_timeout = 0, ev_rx_data = 0, ev_tx_ready = 0;
    logic       ev_modem = 0, ev_xoff_match = 0, ev_xon_match = 0, ev_special_match = 0;
    logic       rts_n_pin = 1, cts_n_pin = 1;
    logic       rd_ident = 0, rd_line_stat = 0, rd_rx_hold = 0, rd_modem_stat = 0, wr_tx_hold = 0;
    logic       irq;
    logic [5:0] ident_code;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst(rst), .ier_en(ier_en),
        .ev_line_err(ev_line_err), .ev_rx_timeout(ev_rx_timeout),
        .ev_rx_data(ev_rx_data), .ev_tx_ready(ev_tx_ready), .ev_modem(ev_modem),
        .ev_xoff_match(ev_xoff_match), .ev_xon_match(ev_xon_match),
        .ev_special_match(ev_special_match),
        .rts_n_pin(rts_n_pin), .cts_n_pin(cts_n_pin),
        .rd_ident(rd_ident), .rd_line_stat(rd_line_stat), .rd_rx_hold(rd_rx_hold),
        .rd_modem_stat(rd_modem_stat), .wr_tx_hold(wr_tx_hold),
        .irq(irq), .ident_code(ident_code)
    );

    // Vector: {ier[27:24], events[23:16], access[15:11], irq[10], code[9:4], req[3:0]}
    // events: line, timeout, rxdata, txready, modem, xoff, xon, special
    // access: ident, linestat, rxhold, modemstat, txwrite
    localparam logic [27:0] VEC [NVEC] = '{
        {4'hF, 8'b00010000, 5'b00000, 1'b1, 6'b000010, 4'd4},  // R4 tx set
        {4'hF, 8'b00001000, 5'b00000, 1'b1, 6'b000010, 4'd4},  // R4 tx outranks modem
        {4'hF, 8'b00000000, 5'b10000, 1'b1, 6'b000000, 4'd4},  // R4 ident read clears tx
        {4'hF, 8'b00000000, 5'b10000, 1'b1, 6'b000000, 4'd5},  // R5 modem survives ident read
        {4'hF, 8'b00000000, 5'b00010, 1'b0, 6'b000001, 4'd6},  // R6 modem read clears
        {4'hF, 8'b00100000, 5'b00000, 1'b1, 6'b000100, 4'd3},  // R3 rx data
        {4'hF, 8'b01000000, 5'b00000, 1'b1, 6'b001100, 4'd3},  // R3 timeout ahead of data
        {4'hF, 8'b10000000, 5'b00000, 1'b1, 6'b000110, 4'd2},  // R2 line on top
        {4'hF, 8'b00000000, 5'b00100, 1'b1, 6'b000110, 4'd2},  // R2 rx read leaves line
        {4'hF, 8'b00000000, 5'b01000, 1'b0, 6'b000001, 4'd2},  // R2 line read clears
        {4'hF, 8'b00010000, 5'b00001, 1'b1, 6'b000010, 4'd10}, // R10 tx set beats write
        {4'hF, 8'b00000000, 5'b00001, 1'b0, 6'b000001, 4'd4},  // R4 write clears tx
        {4'hF, 8'b00000100, 5'b00000, 1'b1, 6'b010000, 4'd7},  // R7 xoff set
        {4'hF, 8'b00000000, 5'b10000, 1'b1, 6'b010000, 4'd7},  // R7 ident read no effect
        {4'hF, 8'b00000010, 5'b00000, 1'b0, 6'b000001, 4'd7},  // R7 xon clears
        {4'hF, 8'b00000001, 5'b00000, 1'b1, 6'b010000, 4'd7},  // R7 special set
        {4'hF, 8'b00000000, 5'b10000, 1'b0, 6'b000001, 4'd7},  // R7 ident read clears special
        {4'h0, 8'b00001000, 5'b00000, 1'b0, 6'b000001, 4'd9},  // R9 polled mode quiet
        {4'h8, 8'b00000000, 5'b00000, 1'b1, 6'b000000, 4'd12}, // R12 modem kept, now shown
        {4'h1, 8'b10000000, 5'b00000, 1'b0, 6'b000001, 4'd9},  // R9 line and modem masked
        {4'h4, 8'b00000000, 5'b00000, 1'b1, 6'b000110, 4'd12}, // R12 line appears
        {4'hF, 8'b00000000, 5'b01000, 1'b1, 6'b000000, 4'd2},  // R2 line cleared, modem next
        {4'hF, 8'b00001000, 5'b00010, 1'b1, 6'b000000, 4'd10}, // R10 modem set beats read
        {4'hF, 8'b00000000, 5'b00010, 1'b0, 6'b000001, 4'd6},  // R6 modem read clears
        {4'hF, 8'b00000110, 5'b00000, 1'b1, 6'b010000, 4'd10}, // R10 xoff beats xon
        {4'hF, 8'b00000010, 5'b00000, 1'b0, 6'b000001, 4'd7},  // R7 xon clears
        {4'hF, 8'b00100000, 5'b00100, 1'b1, 6'b000100, 4'd10}, // R10 rx data beats read
        {4'hF, 8'b00000000, 5'b00100, 1'b0, 6'b000001, 4'd3}   // R3 rx read clears
    };

    task automatic check(input string tag, input logic exp_irq, input logic [5:0] exp_code);
        checks++;
        if (irq !== exp_irq || ident_code !== exp_code) begin
            failures++;
            $display("FAIL %s: irq=%0b code=%06b expected irq=%0b code=%06b",
                     tag, irq, ident_code, exp_irq, exp_code);
        end
    endtask

    task automatic clear_strobes();
        {ev_line_err, ev_rx_timeout, ev_rx_data, ev_tx_ready,
         ev_modem, ev_xoff_match, ev_xon_match, ev_special_match} = '0;
        {rd_ident, rd_line_stat, rd_rx_hold, rd_modem_stat, wr_tx_hold} = '0;
    endtask

    // Called at a falling edge; inputs are applied for one cycle
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                failures++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        rst = 1'b1;
        ier_en = 4'hF;
        repeat (3) @(negedge clk);
        check("R1 reset state", 1'b0, 6'b000001);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", 1'b0, 6'b000001);

        for (int i = 0; i < NVEC; i++) begin
            ier_en = VEC[i][27:24];
            {ev_line_err, ev_rx_timeout, ev_rx_data, ev_tx_ready,
             ev_modem, ev_xoff_match, ev_xon_match, ev_special_match} = VEC[i][23:16];
            {rd_ident, rd_line_stat, rd_rx_hold, rd_modem_stat, wr_tx_hold} = VEC[i][15:11];
            tick();
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][10], VEC[i][9:4]);
        end

        // R11: no change before the edge, change right after it
        ier_en = 4'hF;
        ev_tx_ready = 1'b1;
        #1;
        check("R11 before edge", 1'b0, 6'b000001);
        @(posedge clk);
        #1;
        check("R11 after edge", 1'b1, 6'b000010);
        @(negedge clk);
        clear_strobes();
        wr_tx_hold = 1'b1;
        #1;
        check("R11 clear before edge", 1'b1, 6'b000010);
        tick();
        check("R11 clear after edge", 1'b0, 6'b000001);

        // R8: handshake pins
        rts_n_pin = 1'b0;
        tick();
        check("R8 falling pin ignored", 1'b0, 6'b000001);
        rts_n_pin = 1'b1;
        tick();
        check("R8 rts rise", 1'b1, 6'b100000);
        rd_ident = 1'b1;
        tick();
        check("R8 ident read clears", 1'b0, 6'b000001);
        cts_n_pin = 1'b0;
        tick();
        cts_n_pin = 1'b1;
        ev_modem = 1'b1;
        tick();
        check("R8 modem outranks pin", 1'b1, 6'b000000);
        rd_ident = 1'b1;
        tick();
        check("R5 pin kept under modem", 1'b1, 6'b000000);
        rd_modem_stat = 1'b1;
        tick();
        check("R8 cts rise pending", 1'b1, 6'b100000);
        rd_ident = 1'b1;
        tick();
        check("R8 cleared", 1'b0, 6'b000001);

        // R1: mid-run reset drops pending sources
        ev_line_err = 1'b1;
        ev_modem = 1'b1;
        tick();
        check("R2 line before reset", 1'b1, 6'b000110);
        rst = 1'b1;
        tick();
        check("R1 reset clears all", 1'b0, 6'b000001);
        rst = 1'b0;
        tick();
        check("R1 idle after second reset", 1'b0, 6'b000001);

        finish_run();
    end
endmodule